// File: doc/BRIEF.md
# Iterative AES-128 Block Decryptor

This block recovers 128-bit plaintext blocks from AES-128 ciphertext in electronic-codebook fashion. It runs the inverse cipher one round per clock. The caller first loads a 128-bit key. During a ten-cycle setup phase the block expands that key into all eleven round keys and keeps them, because decryption uses the round keys from the last one back to the first.

After setup, each ciphertext block offered with a valid strobe produces one plaintext block with a one-cycle valid pulse. Busy and done flags frame each block, and each block has a fixed latency. The same key serves every following block until a new key is loaded. A strobe that arrives while either phase is running is dropped without effect. The next block may be offered in the cycle that follows a done flag, so decryption can run back to back with no idle gap.

Top module: `aes128_ecb_dec`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, key_busy, key_done, dec_busy, dec_done and pt_valid are all 0.
- R2: A key_load sampled while the block is idle is accepted. key_busy is then 1 for exactly 10 consecutive cycles starting in the next cycle, and key_done is 1 only in the last of them.
- R3: A ct_valid sampled while the block is idle and key_load is 0 is accepted. dec_busy is then 1 for exactly 10 consecutive cycles starting in the next cycle, and dec_done is 1 only in the last of them.
- R4: pt_valid is a single-cycle pulse in the cycle right after dec_done, which is 11 cycles after the accepting cycle. pt_block carries the result in that cycle and holds it until the next pulse.
- R5: key_load and ct_valid have no effect in any cycle where key_busy or dec_busy is 1. key_busy and dec_busy are never 1 together.
- R6: If key_load and ct_valid are both 1 in an idle cycle, the key load is taken and the ciphertext is dropped.
- R7: A ct_valid in the cycle after dec_done is accepted, and its dec_busy follows with no idle cycle.
- R8: The round keys of the most recent load serve every later block. A new load replaces them for the blocks that follow.
- R9: pt_block is the AES-128 inverse cipher of the accepted ct_block under the loaded key. Both use standard byte order: bits 127:120 hold byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_load | input | 1 | Strobe to start key setup with key_word |
| key_word | input | 128 | Cipher key, byte 0 in bits 127:120 |
| key_busy | output | 1 | Key setup in progress |
| key_done | output | 1 | Last cycle of key setup |
| ct_valid | input | 1 | Strobe to start decrypting ct_block |
| ct_block | input | 128 | Ciphertext block |
| dec_busy | output | 1 | Decryption in progress |
| dec_done | output | 1 | Last round cycle of a decryption |
| pt_valid | output | 1 | One-cycle pulse: pt_block is fresh |
| pt_block | output | 128 | Recovered plaintext block |

## Verification
Two of the block's functions can fall in the same cycle in several ways. A key load and a ciphertext strobe can arrive together while the block is idle. A new ciphertext strobe can arrive in the cycle where the previous result is being presented. A strobe of either kind can land in the done cycle of a running phase. The bench provokes each case with exact cycle placement. A behavioural model counts the remaining busy cycles and keeps the expected plaintext, and the bench compares every flag and the data against that model in every cycle. Reference vectors for two keys confirm that the accepted operation was the correct one, and that the dropped one left both the output and the stored key schedule untouched.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;

    localparam int unsigned BLK_W = 128;
    localparam int unsigned NROUND = 10;

    function automatic logic [7:0] xt(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xt(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (zero maps to zero)
    function automatic logic [7:0] ginv(input logic [7:0] x);
        logic [7:0] p2, p3, p12, p15, p240;
        p2   = gmul(x, x);
        p3   = gmul(p2, x);
        p12  = gmul(gmul(p3, p3), gmul(p3, p3));
        p15  = gmul(p12, p3);
        p240 = gmul(p15, p15);
        p240 = gmul(p240, p240);
        p240 = gmul(p240, p240);
        p240 = gmul(p240, p240);
        return gmul(gmul(p240, p12), p2);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return 8'((v << n) | (v >> (8 - n)));
    endfunction

    function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
        logic [7:0] b;
        b = ginv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sbox_inv(input logic [7:0] s);
        return ginv(rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05);
    endfunction

    function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
        logic [7:0] a0, a1, a2, a3;
        a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
        return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

    // one step of the key schedule: round key i from round key i-1
    function automatic logic [127:0] next_rkey(input logic [127:0] prev, input logic [7:0] rc);
        logic [31:0] w0, w1, w2, w3, rot, t, n0, n1, n2, n3;
        w0 = prev[127:96]; w1 = prev[95:64]; w2 = prev[63:32]; w3 = prev[31:0];
        rot = {w3[23:0], w3[31:24]};
        t = {sbox_fwd(rot[31:24]) ^ rc, sbox_fwd(rot[23:16]),
             sbox_fwd(rot[15:8]), sbox_fwd(rot[7:0])};
        n0 = w0 ^ t;
        n1 = w1 ^ n0;
        n2 = w2 ^ n1;
        n3 = w3 ^ n2;
        return {n0, n1, n2, n3};
    endfunction

endpackage

// File: rtl/aes_key_store.sv
module aes_key_store
    import aes_dec_pkg::*;
#(
    parameter int unsigned NR = NROUND,
    localparam int unsigned NRK = NR + 1,
    localparam int unsigned CW = $clog2(NRK + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [127:0]              key_in,
    output logic                      busy,
    output logic                      done,
    output logic [NRK-1:0][127:0]     rk_all
);

    typedef struct packed {
        logic                  run;
        logic [CW-1:0]         idx;
        logic [7:0]            rc;
        logic [NRK-1:0][127:0] rk;
    } ks_t;

    ks_t ks_d, ks_q;
    logic last_step;

    always_comb begin
        ks_d      = ks_q;
        last_step = ks_q.run && (ks_q.idx == CW'(NRK - 1));
        if (ks_q.run) begin
            ks_d.rk[ks_q.idx] = next_rkey(ks_q.rk[ks_q.idx - CW'(1)], ks_q.rc);
            ks_d.rc = xt(ks_q.rc);
            if (last_step) begin
                ks_d.run = 1'b0;
            end else begin
                ks_d.idx = ks_q.idx + CW'(1);
            end
        end else if (start) begin
            ks_d.rk[0] = key_in;
            ks_d.idx   = CW'(1);
            ks_d.rc    = 8'h01;
            ks_d.run   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= '0;
        end else begin
            ks_q <= ks_d;
        end
    end

    assign busy   = ks_q.run;
    assign done   = last_step;
    assign rk_all = ks_q.rk;

endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
    import aes_dec_pkg::*;
(
    input  logic [127:0] st_in,
    input  logic [127:0] rkey,
    input  logic         final_rnd,
    output logic [127:0] st_out
);

    logic [127:0] subbed;
    logic [127:0] keyed;
    logic [127:0] mixed;

    // inverse row rotation folded into the byte substitution wiring
    for (genvar r = 0; r < 4; r++) begin : g_row
        for (genvar c = 0; c < 4; c++) begin : g_col
            localparam int DST = r + 4 * c;
            localparam int SRC = r + 4 * ((c - r + 4) % 4);
            assign subbed[127 - 8 * DST -: 8] = sbox_inv(st_in[127 - 8 * SRC -: 8]);
        end
    end

    assign keyed = subbed ^ rkey;

    for (genvar c = 0; c < 4; c++) begin : g_mix
        assign mixed[127 - 32 * c -: 32] = inv_mix_col(keyed[127 - 32 * c -: 32]);
    end

    assign st_out = final_rnd ? keyed : mixed;

endmodule

// File: rtl/aes128_ecb_dec.sv
module aes128_ecb_dec
    import aes_dec_pkg::*;
#(
    parameter int unsigned NR = NROUND,
    localparam int unsigned NRK = NR + 1,
    localparam int unsigned CW = $clog2(NRK + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_load,
    input  logic [127:0] key_word,
    output logic         key_busy,
    output logic         key_done,
    input  logic         ct_valid,
    input  logic [127:0] ct_block,
    output logic         dec_busy,
    output logic         dec_done,
    output logic         pt_valid,
    output logic [127:0] pt_block
);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] rnd;
        logic [127:0]  st;
        logic [127:0]  pt;
        logic          pv;
    } dec_t;

    dec_t dq_d, dq_q;

    logic                  idle;
    logic                  key_go;
    logic                  dec_go;
    logic                  ks_busy;
    logic                  ks_done;
    logic [NRK-1:0][127:0] rk_all;
    logic [127:0]          rnd_out;
    logic                  rnd_last;

    assign idle   = !ks_busy && !dq_q.run;
    assign key_go = idle && key_load;
    assign dec_go = idle && ct_valid && !key_load;

    aes_key_store #(.NR(NR)) u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (key_go),
        .key_in (key_word),
        .busy   (ks_busy),
        .done   (ks_done),
        .rk_all (rk_all)
    );

    assign rnd_last = (dq_q.rnd == '0);

    aes_inv_round u_round (
        .st_in     (dq_q.st),
        .rkey      (rk_all[dq_q.rnd]),
        .final_rnd (rnd_last),
        .st_out    (rnd_out)
    );

    always_comb begin
        dq_d    = dq_q;
        dq_d.pv = 1'b0;
        if (dq_q.run) begin
            dq_d.st = rnd_out;
            if (rnd_last) begin
                dq_d.run = 1'b0;
                dq_d.pt  = rnd_out;
                dq_d.pv  = 1'b1;
            end else begin
                dq_d.rnd = dq_q.rnd - CW'(1);
            end
        end else if (dec_go) begin
            dq_d.st  = ct_block ^ rk_all[NR];
            dq_d.rnd = CW'(NR - 1);
            dq_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else begin
            dq_q <= dq_d;
        end
    end

    assign key_busy = ks_busy;
    assign key_done = ks_done;
    assign dec_busy = dq_q.run;
    assign dec_done = dq_q.run && rnd_last;
    assign pt_valid = dq_q.pv;
    assign pt_block = dq_q.pt;

endmodule

// File: rtl/aes128_ecb_dec_chk.sv
module aes128_ecb_dec_chk #(
    parameter int unsigned NR = 10
) (
    input logic clk,
    input logic rst_n,
    input logic key_load,
    input logic ct_valid,
    input logic key_busy,
    input logic key_done,
    input logic dec_busy,
    input logic dec_done,
    input logic pt_valid
);

    logic [7:0] krun, drun;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            krun <= '0;
            drun <= '0;
        end else begin
            krun <= key_busy ? krun + 8'd1 : 8'd0;
            drun <= dec_busy ? drun + 8'd1 : 8'd0;
        end
    end

    a_r2_key_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |-> key_busy);
    a_r2_key_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |=> !key_busy);
    a_r2_key_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_busy) |-> (krun == 8'(NR)));
    a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_valid && !key_load && !key_busy && !dec_busy) |=> (dec_busy && !key_busy));
    a_r3_dec_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dec_busy) |-> (drun == 8'(NR)));
    a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |-> dec_busy);
    a_r4_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> pt_valid);
    a_r4_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> $past(dec_done));
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_busy && dec_busy));
    a_r5_no_key_during_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_busy && !dec_done) |=> !key_busy);
    a_r5_no_dec_during_key: assert property (@(posedge clk) disable iff (!rst_n)
        (key_busy && !key_done) |=> !dec_busy);
    a_r6_key_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (key_load && ct_valid && !key_busy && !dec_busy) |=> (key_busy && !dec_busy));

endmodule

bind aes128_ecb_dec aes128_ecb_dec_chk #(.NR(NR)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_load (key_load),
    .ct_valid (ct_valid),
    .key_busy (key_busy),
    .key_done (key_done),
    .dec_busy (dec_busy),
    .dec_done (dec_done),
    .pt_valid (pt_valid)
);

// File: tb/aes128_ecb_dec_tb_top.sv
`timescale 1ns/1ps
module aes128_ecb_dec_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_word = '0;
    logic         ct_valid = 1'b0;
    logic [127:0] ct_block = '0;
    logic         key_busy, key_done, dec_busy, dec_done, pt_valid;
    logic [127:0] pt_block;

    always #5 clk = ~clk;

    aes128_ecb_dec dut_i (
        .clk(clk), .rst_n(rst_n),
        .key_load(key_load), .key_word(key_word),
        .key_busy(key_busy), .key_done(key_done),
        .ct_valid(ct_valid), .ct_block(ct_block),
        .dec_busy(dec_busy), .dec_done(dec_done),
        .pt_valid(pt_valid), .pt_block(pt_block)
    );

    // reference vectors
    localparam logic [127:0] KA = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] KB = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] CA = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] PA = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] CB1 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] PB1 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] CB2 = 128'h3ad77bb40d7a3660a89ecaf32466ef97;
    localparam logic [127:0] PB2 = 128'h6bc1bee22e409f96e93d7e117393172a;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural model state
    int           key_left = 0;
    int           dec_left = 0;
    logic [127:0] m_key = '0;
    logic [127:0] m_pend = '0;
    bit           m_pend_known = 0;
    bit           e_pv = 0;
    logic [127:0] e_pt = '0;
    bit           e_pt_known = 0;

    function automatic bit lookup(input logic [127:0] k, input logic [127:0] c,
                                  output logic [127:0] p);
        p = '0;
        if (k == KA && c == CA) begin p = PA; return 1; end
        if (k == KB && c == CB1) begin p = PB1; return 1; end
        if (k == KB && c == CB2) begin p = PB2; return 1; end
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_left = 0; dec_left = 0; e_pv = 0; e_pt = '0; e_pt_known = 1;
        end else begin
            bit idle;
            idle = (key_left == 0) && (dec_left == 0);
            e_pv = 0;
            if (dec_left > 0) begin
                dec_left--;
                if (dec_left == 0) begin
                    e_pv = 1; e_pt = m_pend; e_pt_known = m_pend_known;
                end
            end
            if (key_left > 0) key_left--;
            if (idle) begin
                if (key_load) begin
                    key_left = 10; m_key = key_word;
                end else if (ct_valid) begin
                    dec_left = 10;
                    m_pend_known = lookup(m_key, ct_block, m_pend);
                end
            end
        end
    end

    task automatic report(input string req, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
        $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit bad;
            bad = 0;
            n_cmp++;
            if (key_busy !== (key_left > 0)) begin bad = 1; report("R2", "key_busy", 128'(key_busy), 128'(key_left > 0)); end
            if (key_done !== (key_left == 1)) begin bad = 1; report("R2", "key_done", 128'(key_done), 128'(key_left == 1)); end
            if (dec_busy !== (dec_left > 0)) begin bad = 1; report("R3", "dec_busy", 128'(dec_busy), 128'(dec_left > 0)); end
            if (dec_done !== (dec_left == 1)) begin bad = 1; report("R3", "dec_done", 128'(dec_done), 128'(dec_left == 1)); end
            if (pt_valid !== e_pv) begin bad = 1; report("R4", "pt_valid", 128'(pt_valid), 128'(e_pv)); end
            if (e_pt_known && pt_block !== e_pt) begin bad = 1; report("R9", "pt_block", pt_block, e_pt); end
            if (bad) n_bad++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
            finish_run();
        end
    end

    task automatic pulse(input bit kv, input logic [127:0] k, input bit cv, input logic [127:0] c);
        @(negedge clk); #1;
        key_load = kv; key_word = k; ct_valid = cv; ct_block = c;
        @(negedge clk); #1;
        key_load = 0; ct_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (key_busy || dec_busy);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!dec_done);
    endtask

    initial begin
        // R1: outputs low during reset and just after release
        repeat (3) @(negedge clk);
        n_cmp++;
        if ({key_busy, key_done, dec_busy, dec_done, pt_valid} !== 5'b0) begin
            n_bad++;
            report("R1", "flags in reset", 128'({key_busy, key_done, dec_busy, dec_done, pt_valid}), 128'(0));
        end
        #1 rst_n = 1;

        // R2: key setup, with R5 drops of both strobes while busy
        pulse(1, KA, 0, '0);
        pulse(0, '0, 1, CA);
        pulse(1, KB, 0, '0);
        wait_idle();

        // R9 / R4: first decryption, with R5 drops during it
        pulse(0, '0, 1, CA);
        pulse(1, KB, 0, '0);
        pulse(0, '0, 1, CB1);
        wait_idle();
        repeat (2) @(negedge clk);

        // R8: key KA still in use after the dropped reload
        pulse(0, '0, 1, CA);
        // R5: strobe landing in the done cycle is dropped
        wait_done();
        #1 ct_valid = 1; ct_block = CA;
        @(negedge clk); #1 ct_valid = 0;
        wait_idle();

        // R7: back-to-back, next block in the cycle after done
        pulse(0, '0, 1, CA);
        wait_done();
        pulse(0, '0, 1, CA);
        wait_done();
        pulse(0, '0, 1, CA);
        wait_idle();

        // R6: key and ciphertext in the same idle cycle -> key wins
        pulse(1, KB, 1, CA);
        wait_idle();

        // R8: the new key serves several blocks
        pulse(0, '0, 1, CB1);
        wait_done();
        pulse(0, '0, 1, CB2);
        wait_idle();

        // R8: reload the first key and reuse it
        pulse(1, KA, 0, '0);
        wait_idle();
        pulse(0, '0, 1, CA);
        wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule